// File: doc/BRIEF.md
# Selectable Baud Tick Generator

This block derives a one-clock-wide baud strobe from a 50 MHz system clock. It works in two stages. A fixed prescaler makes a base strobe at the fastest supported rate, 115200 baud, by dividing the clock by 434. A small secondary counter then passes every Nth base strobe through as the baud strobe. N is a whole number picked by a 3-bit rate code. Because all slower rates are integer multiples of the base period, no fractional accumulation is needed.

A visible indicator rides on the base strobe. An 8-bit counter steps once per base strobe, and its bit 4 drives an LED. The LED therefore blinks at one rate whatever code is selected. Changing the rate code restarts the secondary counter, so the new rate takes effect on a clean count. All state is cleared by a synchronous, active-low reset.

Top module: `baud_tick_gen`

## Requirements
- R1: `base_tick` is high for exactly one clock in every 434 clocks. The prescaler counts 0 to 433 and wraps, so the period is exactly 434 and not 435.
- R2: `baud_tick` period in clocks is 434 times the ratio for the code: code 000 gives ratio 1 (434), 001 gives 2 (868), 010 gives 3 (1302) and 011 gives 6 (2604).
- R3: `baud_tick` is only ever high in a cycle where `base_tick` is also high, and it lasts one clock.
- R4: Codes 100, 101, 110 and 111 all fall back to ratio 12, a 5208-clock baud period.
- R5: `led` is bit 4 of an 8-bit counter that advances once per base strobe. It changes only in the cycle after a base strobe, and its period is 32 base periods (13888 clocks).
- R6: The LED period is the same for rate code 000 and rate code 100.
- R7: A change of rate code restarts the secondary count from zero. If the change lands between base strobes, the first baud strobe arrives on the Nth base strobe after the change, where N is the new ratio.
- R8: While `rst_n` is low at a clock edge, every counter is cleared, and `base_tick`, `baud_tick` and `led` read 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 50 MHz nominal |
| rst_n | input | 1 | Synchronous reset, active low |
| rate_sel | input | 3 | Rate code selecting the secondary ratio |
| baud_tick | output | 1 | One-clock strobe at the selected baud rate |
| base_tick | output | 1 | One-clock strobe at the fixed fastest rate |
| led | output | 1 | Indicator bit, blink rate independent of the code |

## Verification
Each of the eight rate codes is held while successive baud strobe intervals are measured. This separates the four distinct ratios from one another, and it shows that the four fallback codes all behave alike. The LED period is measured under the fastest and the slowest code. A rate mismatch between them would expose an indicator tied to the wrong strobe. A switch from the slowest code to ratio 2, made part way through a count, counts base strobes to the first baud strobe and so tells a restarted divider from one carrying a stale count. A reset pulse applied mid-run shows that every output clears.

// File: rtl/baud_pkg.sv
// Shared definitions for the baud tick generator.
// Assumes a 3-bit rate code; unlisted codes fall back to the slowest ratio.
package baud_pkg;

    localparam int RATE_SEL_W = 3;
    localparam int RATIO_W    = 4;

    // Map a rate code to its whole-number multiple of the base period.
    function automatic logic [RATIO_W-1:0] ratio_of(input logic [RATE_SEL_W-1:0] code);
        logic [RATIO_W-1:0] r;
        case (code)
            3'b000:  r = 4'd1;
            3'b001:  r = 4'd2;
            3'b010:  r = 4'd3;
            3'b011:  r = 4'd6;
            default: r = 4'd12;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/base_prescaler.sv
// Fixed prescaler: divides the system clock by DIV and emits a
// one-clock strobe on each wrap. Counts 0..DIV-1 exactly.
// Assumes DIV >= 2.
module base_prescaler #(
    parameter int DIV = 434
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = $clog2(DIV);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt;

    // Advance the count and raise the strobe on the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/rate_divider.sv
// Secondary divider: passes every Nth base strobe as the baud strobe,
// N taken from the rate code. A code change clears the count.
// Assumes base strobes are at least two clocks apart.
module rate_divider
    import baud_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [RATE_SEL_W-1:0] rate_sel,
    input  logic                  base_tick,
    output logic                  baud_tick
);
    logic [RATE_SEL_W-1:0] sel_q;
    logic [RATIO_W-1:0]    cnt;
    logic [RATIO_W-1:0]    term;
    logic                  sel_chg;
    logic                  at_term;

    assign sel_chg = (rate_sel != sel_q);
    assign term    = ratio_of(sel_q) - 1'b1;
    assign at_term = (cnt == term);

    // Strobe on the base tick that completes the count, unless restarting.
    assign baud_tick = base_tick & at_term & ~sel_chg;

    // Track the code and count base strobes, restarting on a code change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= rate_sel;
            cnt   <= '0;
        end else if (sel_chg) begin
            sel_q <= rate_sel;
            cnt   <= '0;
        end else if (base_tick) begin
            cnt <= at_term ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/led_blinker.sv
// Indicator: a free-running counter stepped by the base strobe; one
// chosen bit drives the LED. Assumes OUT_BIT < W.
module led_blinker #(
    parameter int W       = 8,
    parameter int OUT_BIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic led
);
    logic [W-1:0] cnt;

    // Step the indicator counter once per base strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (step)  cnt <= cnt + 1'b1;
    end

    assign led = cnt[OUT_BIT];
endmodule

// File: rtl/baud_tick_gen.sv
// Top: fixed prescaler to the fastest rate, then a selectable integer
// divider; LED driven from the fixed strobe. Synchronous active-low reset.
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int BASE_DIV = 434,
    parameter int LED_W    = 8,
    parameter int LED_BIT  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [RATE_SEL_W-1:0] rate_sel,
    output logic                  baud_tick,
    output logic                  base_tick,
    output logic                  led
);
    base_prescaler #(.DIV(BASE_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (base_tick)
    );

    rate_divider u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_sel  (rate_sel),
        .base_tick (base_tick),
        .baud_tick (baud_tick)
    );

    led_blinker #(.W(LED_W), .OUT_BIT(LED_BIT)) u_led (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (base_tick),
        .led   (led)
    );
endmodule

// File: rtl/baud_tick_gen_chk.sv
// Checker for baud_tick_gen: base strobe spacing, strobe alignment,
// LED change timing and reset clearing. Bound to the top below.
module baud_tick_gen_chk #(
    parameter int BASE_DIV = 434
) (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic base_tick,
    input logic led
);
    logic [15:0] gap;
    logic        seen;

    // Count clocks since the last base strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (base_tick) begin
            gap  <= 16'd1;
            seen <= 1'b1;
        end else begin
            gap <= gap + 1'b1;
        end
    end

    // R1: base strobes are exactly BASE_DIV clocks apart.
    p_base_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (base_tick && seen) |-> (gap == 16'(BASE_DIV)));

    // R1: base strobe is one clock wide.
    p_base_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
        base_tick |=> !base_tick);

    // R3: baud strobe only with a base strobe.
    p_baud_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> base_tick);

    // R5: LED holds unless a base strobe came the cycle before.
    p_led_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !base_tick |=> $stable(led));

    // R8: reset clears outputs.
    p_reset_clears_r8: assert property (@(posedge clk)
        !rst_n |=> (!base_tick && !baud_tick && !led));
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.BASE_DIV(BASE_DIV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .base_tick (base_tick),
    .led       (led)
);

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] rate_sel = 3'b000;
    logic       baud_tick, base_tick, led;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int ticks_seen = 0;
    int last_tick = 0;

    typedef struct { int exp; int code; } item_t;
    item_t q[$];

    baud_tick_gen u_baud_tick_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_sel  (rate_sel),
        .baud_tick (baud_tick),
        .base_tick (base_tick),
        .led       (led)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: on each baud strobe, pop an expected interval and compare.
    always @(negedge clk) begin
        if (rst_n && baud_tick) begin
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                check(it.code >= 4 ? "R4" : "R2", cyc - last_tick, it.exp);
            end
            last_tick = cyc;
            ticks_seen++;
        end
    end

    // Driver: select a code, skip the restart interval, queue expectations.
    task automatic run_rate(input logic [2:0] code, input int exp);
        int t0;
        @(negedge clk);
        rate_sel = code;
        t0 = ticks_seen;
        wait (ticks_seen == t0 + 1);
        q.push_back('{exp, code});
        q.push_back('{exp, code});
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    task automatic led_period(output int per);
        logic prev;
        int   r0;
        prev = led;
        while (!(led && !prev)) begin prev = led; @(negedge clk); end
        r0 = cyc;
        prev = led;
        @(negedge clk);
        while (!(led && !prev)) begin prev = led; @(negedge clk); end
        per = cyc - r0;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int p0, p1, nb, bt;
        repeat (3) @(negedge clk);
        check("R8 base", base_tick, 0);
        check("R8 baud", baud_tick, 0);
        check("R8 led", led, 0);
        rst_n = 1'b1;

        // R1: base period from two consecutive base strobes
        wait (base_tick); @(negedge clk); p0 = cyc;
        @(negedge clk); wait (base_tick); @(negedge clk);
        check("R1", cyc - p0, 434);

        run_rate(3'b000, 434);   // R2
        run_rate(3'b001, 868);   // R2
        run_rate(3'b010, 1302);  // R2
        run_rate(3'b011, 2604);  // R2
        run_rate(3'b100, 5208);  // R4
        run_rate(3'b101, 5208);  // R4
        run_rate(3'b110, 5208);  // R4
        run_rate(3'b111, 5208);  // R4

        // R7: switch from ratio 12 to ratio 2 mid-count
        rate_sel = 3'b100;
        bt = ticks_seen;
        wait (ticks_seen == bt + 1);
        nb = 0;
        while (nb < 5) begin @(negedge clk); if (base_tick) nb++; end
        rate_sel = 3'b001;
        nb = 0; bt = 0;
        while (bt == 0) begin
            @(negedge clk);
            if (base_tick) nb++;
            if (baud_tick) bt = 1;
        end
        check("R7 base strobes to first baud", nb, 2);

        // R5/R6: LED period under fastest and fallback codes
        rate_sel = 3'b000;
        led_period(p0);
        check("R5 led period code000", p0, 13888);
        rate_sel = 3'b100;
        led_period(p1);
        check("R6 led period code100", p1, 13888);
        check("R6 equal periods", p1, p0);

        // R8: mid-run reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R8 base mid", base_tick, 0);
        check("R8 led mid", led, 0);
        check("R8 baud mid", baud_tick, 0);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule